// File: doc/BRIEF.md
# Bit-Level TDM Line Router

This block is a time-division serial port for a basic-rate line bus. It runs in the system clock domain and watches an external bit clock, frame sync and data line. It brings those signals across with synchronizers and acts on the edges it detects there. A small routing table holds one entry for each bit position of the frame. For every bit, the entry decides whether the bit belongs to one of four serial controller channels, whether a strobe output is raised for an external device, or whether the bit is ignored.

Receive and transmit each have their own table. Received bits are captured on the falling serial clock edge and only when the receive entry enables them. Each captured bit is handed to its channel as a one-cycle valid pulse together with the bit value. On transmit, the line is driven only during enabled positions. The bit changes on the rising serial clock edge and the owning channel gets a one-cycle ready pulse when its bit is taken. The output-enable is low for every other position, so the pad can three-state the line.

The frame length is set only by which entry carries the last-entry flag. This is how 8-bit, 10-bit and four-slot primary-rate layouts are obtained. A configuration input can run the transmit side from the receive clock and sync, so one bus carries both directions.

Top module: `tdm_bit_router`

## Requirements
- R1: While reset is held and right after it, `rx_valid`, `tx_ready`, `rx_strobe`, `tx_strobe`, `tx_oe` and `tx_data` are all 0.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr` in the transmit table when `cfg_tx_sel` is 1, else in the receive table; entry layout is bits [1:0] channel, bit 2 enable, bit 3 strobe, bit 4 last.
- R3: The bit period in which frame sync is seen is not routed; the next bit period is position 0 (one-bit delay).
- R4: At each received position whose entry has enable set, exactly one `rx_valid` bit pulses, the one indexed by the channel field, and `rx_bit` carries the bit; disabled positions produce no pulse.
- R5: Receive data is taken as it stood at the falling serial clock edge; a change shortly after that edge does not alter the captured bit.
- R6: For an enabled transmit position `tx_oe` is 1 and `tx_data` is the selected channel's `tx_in` bit; for a disabled position, or the sync period, `tx_oe` and `tx_data` are 0.
- R7: Transmit outputs change only after a rising serial clock edge, and each enabled position gives a single one-cycle pulse on the `tx_ready` bit of its channel.
- R8: After an entry with the last flag, the next bit is position 0 again, with or without a new sync, so a frame of any length up to the table depth repeats.
- R9: `rx_strobe` and `tx_strobe` are 1 for the whole bit period of a position whose strobe flag is set, independently of the enable flag.
- R10: With `tie_tx_to_rx` at 0 the transmit side follows only `tx_sclk`/`tx_fsync`; at 1 it follows `rx_sclk`/`rx_fsync` and ignores its own pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tx_sel | input | 1 | 1 selects the transmit table, 0 the receive table |
| cfg_addr | input | 4 | Table entry (bit position) to write |
| cfg_wdata | input | 5 | Entry value {last, strobe, enable, channel[1:0]} |
| tie_tx_to_rx | input | 1 | Transmit side uses receive clock and sync |
| rx_sclk | input | 1 | Receive serial bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| tx_sclk | input | 1 | Transmit serial bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_in | input | 4 | Next transmit bit offered by each channel |
| rx_valid | output | 4 | One-cycle pulse per channel for a captured bit |
| rx_bit | output | 1 | Captured bit value |
| rx_strobe | output | 1 | Receive-side strobe for external devices |
| tx_ready | output | 4 | One-cycle pulse per channel when its bit is taken |
| tx_data | output | 1 | Transmit line value |
| tx_oe | output | 1 | Transmit line drive enable (low means high-impedance) |
| tx_strobe | output | 1 | Transmit-side strobe for external devices |

## Verification
Every serial edge passes two synchronizer flops and one output register, so each result appears on the third system clock edge after the serial pin changes. It then holds until the next serial edge of the same polarity. The bench drives each half bit period for six system cycles and samples the held strobe and transmit outputs five cycles into that half, well after the result is due and before the next edge. The valid and ready pulses last only one cycle. They are logged on every falling system clock edge and compared in order once the frame has been sent.

// File: rtl/tdm_router_pkg.sv
package tdm_router_pkg;
  localparam int CH_W    = 2;
  localparam int NCH     = 1 << CH_W;
  localparam int ENTRY_W = CH_W + 3;

  typedef struct packed {
    logic            last;
    logic            strobe;
    logic            en;
    logic [CH_W-1:0] ch;
  } route_t;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ser_clk,
  input  logic [W-1:0] ser_in,
  output logic         rise,
  output logic         fall,
  output logic [W-1:0] sig_s
);
  logic [STAGES-1:0] c_q;
  logic [W-1:0]      s_q [STAGES];
  logic              c_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q    <= '0;
      c_prev <= 1'b0;
      for (int i = 0; i < STAGES; i++) s_q[i] <= '0;
    end else begin
      c_q    <= {c_q[STAGES-2:0], ser_clk};
      c_prev <= c_q[STAGES-1];
      s_q[0] <= ser_in;
      for (int i = 1; i < STAGES; i++) s_q[i] <= s_q[i-1];
    end
  end

  assign rise  = c_q[STAGES-1] & ~c_prev;
  assign fall  = ~c_q[STAGES-1] & c_prev;
  assign sig_s = s_q[STAGES-1];
endmodule

// File: rtl/tdm_route_tbl.sv
module tdm_route_tbl
  import tdm_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  route_t        wdata,
  input  logic [AW-1:0] raddr,
  output route_t        rdata
);
  route_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fall,
  input  logic           sync_s,
  input  logic           data_s,
  input  route_t         entry,
  output logic [AW-1:0]  pos,
  output logic [NCH-1:0] rx_valid,
  output logic           rx_bit,
  output logic           rx_strobe
);
  logic run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      pos       <= '0;
      rx_valid  <= '0;
      rx_bit    <= 1'b0;
      rx_strobe <= 1'b0;
    end else begin
      rx_valid <= '0;
      if (fall) begin
        if (sync_s) begin
          run       <= 1'b1;
          pos       <= '0;
          rx_strobe <= 1'b0;
        end else if (run) begin
          rx_strobe <= entry.strobe;
          if (entry.en) begin
            rx_valid[entry.ch] <= 1'b1;
            rx_bit             <= data_s;
          end
          pos <= (entry.last || pos == AW'(DEPTH-1)) ? '0 : pos + AW'(1);
        end
      end
    end
  end

  // R4: at most one channel receives a given bit
  p_valid_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_valid));
  // R5: captures happen only on a detected falling serial edge
  p_valid_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (|rx_valid) |-> $past(fall));
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_router_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rise,
  input  logic           sync_s,
  input  route_t         entry,
  input  logic [NCH-1:0] tx_in,
  output logic [AW-1:0]  pos,
  output logic [NCH-1:0] tx_ready,
  output logic           tx_data,
  output logic           tx_oe,
  output logic           tx_strobe
);
  logic run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      pos       <= '0;
      tx_ready  <= '0;
      tx_data   <= 1'b0;
      tx_oe     <= 1'b0;
      tx_strobe <= 1'b0;
    end else begin
      tx_ready <= '0;
      if (rise) begin
        if (sync_s) begin
          run       <= 1'b1;
          pos       <= '0;
          tx_oe     <= 1'b0;
          tx_data   <= 1'b0;
          tx_strobe <= 1'b0;
        end else if (run) begin
          tx_oe     <= entry.en;
          tx_data   <= entry.en & tx_in[entry.ch];
          tx_strobe <= entry.strobe;
          if (entry.en) tx_ready[entry.ch] <= 1'b1;
          pos <= (entry.last || pos == AW'(DEPTH-1)) ? '0 : pos + AW'(1);
        end
      end
    end
  end

  // R7: one channel at a time, and only for a single cycle
  p_ready_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_ready));
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (|tx_ready) |=> (tx_ready == '0));
  // R7: line state moves only on a rising serial edge
  p_oe_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(tx_oe) && $stable(tx_data));
  // R6: a consumed bit is always driven onto the line
  p_ready_drives_r6: assert property (@(posedge clk) disable iff (rst)
    (|tx_ready) |-> tx_oe);
endmodule

// File: rtl/tdm_bit_router.sv
module tdm_bit_router
  import tdm_router_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic               cfg_tx_sel,
  input  logic [AW-1:0]      cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic               tie_tx_to_rx,
  input  logic               rx_sclk,
  input  logic               rx_fsync,
  input  logic               rx_sdata,
  input  logic               tx_sclk,
  input  logic               tx_fsync,
  input  logic [NCH-1:0]     tx_in,
  output logic [NCH-1:0]     rx_valid,
  output logic               rx_bit,
  output logic               rx_strobe,
  output logic [NCH-1:0]     tx_ready,
  output logic               tx_data,
  output logic               tx_oe,
  output logic               tx_strobe
);
  logic          rx_rise_unused, rx_fall, tx_rise, tx_fall_unused;
  logic [1:0]    rx_s;
  logic          tx_sync_own;
  logic [AW-1:0] rd_addr [2];
  route_t        rd_ent  [2];

  tdm_edge_sync #(.STAGES(SYNC_STAGES), .W(2)) u_rx_sync (
    .clk(clk), .rst(rst), .ser_clk(rx_sclk), .ser_in({rx_fsync, rx_sdata}),
    .rise(rx_rise_unused), .fall(rx_fall), .sig_s(rx_s));

  tdm_edge_sync #(.STAGES(SYNC_STAGES), .W(1)) u_tx_sync (
    .clk(clk), .rst(rst), .ser_clk(tx_sclk), .ser_in(tx_fsync),
    .rise(tx_rise), .fall(tx_fall_unused), .sig_s(tx_sync_own));

  // One table per direction; index 0 receive, 1 transmit
  for (genvar d = 0; d < 2; d++) begin : g_tbl
    tdm_route_tbl #(.DEPTH(DEPTH)) u_tbl (
      .clk(clk),
      .we(cfg_we && (cfg_tx_sel == d[0])),
      .waddr(cfg_addr),
      .wdata(route_t'(cfg_wdata)),
      .raddr(rd_addr[d]),
      .rdata(rd_ent[d]));
  end

  // Tied mode: transmit edges and sync come from the receive pins
  logic tx_evt, tx_sync_sel;
  assign tx_evt      = tie_tx_to_rx ? rx_rise_unused : tx_rise;
  assign tx_sync_sel = tie_tx_to_rx ? rx_s[1]        : tx_sync_own;

  tdm_rx_lane #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst), .fall(rx_fall), .sync_s(rx_s[1]), .data_s(rx_s[0]),
    .entry(rd_ent[0]), .pos(rd_addr[0]),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_strobe(rx_strobe));

  tdm_tx_lane #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst), .rise(tx_evt), .sync_s(tx_sync_sel),
    .entry(rd_ent[1]), .tx_in(tx_in), .pos(rd_addr[1]),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_oe(tx_oe), .tx_strobe(tx_strobe));

  // R6: line is never driven with a one while released
  p_released_low_r6: assert property (@(posedge clk) disable iff (rst)
    !tx_oe |-> !tx_data);
  // R10: in tied mode the private transmit clock cannot move the line
  p_tie_ignores_own_r10: assert property (@(posedge clk) disable iff (rst)
    (tie_tx_to_rx && !rx_rise_unused) |=> $stable(tx_oe));
  // R1: outputs are quiet on the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (rx_valid == '0 && tx_ready == '0 && !tx_oe));
  // R9: a strobe cannot rise except at a serial edge of its side
  p_rx_strobe_edge_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_strobe) |-> $past(rx_fall));
endmodule

// File: tb/tdm_bit_router_bench.sv
module tdm_bit_router_bench;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0, cfg_tx_sel = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic       tie_tx_to_rx = 1'b1;
  logic       rx_sclk = 1'b0, rx_fsync = 1'b0, rx_sdata = 1'b0;
  logic       tx_sclk = 1'b0, tx_fsync = 1'b0;
  logic [3:0] tx_in = '0;
  logic [3:0] rx_valid, tx_ready;
  logic       rx_bit, rx_strobe, tx_data, tx_oe, tx_strobe;

  tdm_bit_router u_tdm_bit_router (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_tx_sel(cfg_tx_sel),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .tie_tx_to_rx(tie_tx_to_rx),
    .rx_sclk(rx_sclk), .rx_fsync(rx_fsync), .rx_sdata(rx_sdata),
    .tx_sclk(tx_sclk), .tx_fsync(tx_fsync), .tx_in(tx_in),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rx_strobe(rx_strobe),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_oe(tx_oe), .tx_strobe(tx_strobe));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  bit drive_tx = 0;

  int   rx_ch_log [64];
  logic rx_bit_log [64];
  int   rx_n = 0;
  int   rdy_log [64];
  int   rdy_n = 0;
  logic s_oe [32], s_txd [32], s_tstb [32], s_rstb [32];
  int   nb = 0;

  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 4; c++) begin
        if (rx_valid[c] && rx_n < 64) begin
          rx_ch_log[rx_n] = c; rx_bit_log[rx_n] = rx_bit; rx_n++;
        end
        if (tx_ready[c] && rdy_n < 64) begin
          rdy_log[rdy_n] = c; rdy_n++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ent(input bit l, input bit s, input bit e, input int ch);
    return {l, s, e, ch[1:0]};
  endfunction

  task automatic wr(input bit tx, input int a, input logic [4:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tx_sel = tx; cfg_addr = a[3:0]; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_tbl(input bit tx);
    for (int a = 0; a < 16; a++) wr(tx, a, 5'd0);
  endtask

  task automatic clear_logs();
    rx_n = 0; rdy_n = 0; nb = 0;
  endtask

  task automatic send_bit(input bit s, input bit d, input bit glitch = 0);
    @(negedge clk);
    rx_sclk = 1'b1; rx_fsync = s; rx_sdata = d;
    if (drive_tx) begin tx_sclk = 1'b1; tx_fsync = s; end
    repeat (H-1) @(negedge clk);
    s_oe[nb] = tx_oe; s_txd[nb] = tx_data; s_tstb[nb] = tx_strobe;
    @(negedge clk);
    rx_sclk = 1'b0;
    if (drive_tx) tx_sclk = 1'b0;
    if (glitch) begin
      @(negedge clk); rx_sdata = ~d;
      repeat (H-2) @(negedge clk);
    end else begin
      repeat (H-1) @(negedge clk);
    end
    s_rstb[nb] = rx_strobe;
    nb++;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(rx_valid == 0 && tx_ready == 0, "R1 pulses idle", {rx_valid, tx_ready}, 0);
    chk(!tx_oe && !tx_data, "R1 line released", {tx_oe, tx_data}, 0);
    chk(!rx_strobe && !tx_strobe, "R1 strobes low", {rx_strobe, tx_strobe}, 0);
  endtask

  task automatic test_rx_route();
    logic d [8] = '{0, 1, 1, 0, 1, 1, 0, 0};
    int   ech [4] = '{2, 0, 1, 3};
    logic eb [4] = '{0, 1, 1, 0};
    clear_tbl(0);
    wr(0, 0, ent(0, 0, 1, 2)); wr(0, 2, ent(0, 0, 1, 0));
    wr(0, 5, ent(0, 0, 1, 1)); wr(0, 7, ent(1, 0, 1, 3));
    clear_logs();
    send_bit(1, 1);
    for (int k = 0; k < 8; k++) send_bit(0, d[k]);
    settle();
    chk(rx_n == 4, "R4 capture count", rx_n, 4);
    chk(rx_n > 0 && rx_ch_log[0] == 2 && rx_bit_log[0] == 0,
        "R3 first capture is position 0", rx_n > 0 ? rx_bit_log[0] : -1, 0);
    for (int i = 0; i < 4; i++)
      chk(rx_ch_log[i] == ech[i] && rx_bit_log[i] == eb[i],
          "R2/R4 routed bit", rx_ch_log[i] * 10 + rx_bit_log[i], ech[i] * 10 + eb[i]);
  endtask

  task automatic test_rx_edge();
    clear_tbl(0);
    wr(0, 0, ent(1, 0, 1, 0));
    clear_logs();
    send_bit(1, 0);
    send_bit(0, 1, 1);
    send_bit(0, 0, 1);
    settle();
    chk(rx_n == 2 && rx_bit_log[0] == 1 && rx_bit_log[1] == 0,
        "R5 falling-edge sample", rx_n * 10 + rx_bit_log[0] * 2 + rx_bit_log[1], 22);
  endtask

  task automatic test_wrap();
    logic d [4] = '{1, 0, 0, 1};
    clear_tbl(0);
    wr(0, 0, ent(0, 0, 1, 0)); wr(0, 1, ent(1, 0, 1, 1));
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 4; k++) send_bit(0, d[k]);
    settle();
    chk(rx_n == 4, "R8 wrap count", rx_n, 4);
    for (int i = 0; i < 4; i++)
      chk(rx_ch_log[i] == i % 2 && rx_bit_log[i] == d[i], "R8 wrapped position",
          rx_ch_log[i] * 10 + rx_bit_log[i], (i % 2) * 10 + d[i]);
  endtask

  task automatic test_ten_bit();
    clear_tbl(0);
    wr(0, 8, ent(0, 0, 1, 3)); wr(0, 9, ent(1, 0, 1, 2));
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 10; k++) send_bit(0, k != 9);
    send_bit(0, 1); send_bit(0, 1);
    settle();
    chk(rx_n == 2, "R8 ten-bit frame count", rx_n, 2);
    chk(rx_ch_log[0] == 3 && rx_bit_log[0] == 1 && rx_ch_log[1] == 2 && rx_bit_log[1] == 0,
        "R8 ten-bit frame content", rx_ch_log[0] * 10 + rx_ch_log[1], 32);
  endtask

  task automatic test_strobe();
    clear_tbl(0); clear_tbl(1);
    tie_tx_to_rx = 1'b1;
    wr(0, 1, ent(0, 1, 0, 0)); wr(0, 3, ent(1, 0, 0, 0));
    wr(1, 2, ent(0, 1, 0, 0)); wr(1, 3, ent(1, 0, 0, 0));
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 4; k++) send_bit(0, 1);
    settle();
    for (int i = 0; i < 5; i++) begin
      chk(s_rstb[i] == (i == 2), "R9 rx strobe", s_rstb[i], i == 2);
      chk(s_tstb[i] == (i == 3), "R9 tx strobe", s_tstb[i], i == 3);
    end
    chk(rx_n == 0, "R9 strobe without enable captures nothing", rx_n, 0);
  endtask

  task automatic load_tx_tbl();
    clear_tbl(1);
    wr(1, 0, ent(0, 0, 1, 1)); wr(1, 2, ent(0, 0, 1, 3)); wr(1, 3, ent(1, 0, 0, 0));
  endtask

  task automatic test_tx(input logic [3:0] ins);
    logic eoe [5];
    logic ed [5];
    eoe = '{0, 1, 0, 1, 0};
    ed  = '{0, ins[1], 0, ins[3], 0};
    tie_tx_to_rx = 1'b1;
    tx_in = ins;
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 4; k++) send_bit(0, 0);
    settle();
    for (int i = 0; i < 5; i++)
      chk(s_oe[i] == eoe[i] && s_txd[i] == ed[i], "R6 tx line",
          s_oe[i] * 10 + s_txd[i], eoe[i] * 10 + ed[i]);
    chk(rdy_n == 2 && rdy_log[0] == 1 && rdy_log[1] == 3, "R7 ready pulses",
        rdy_n * 100 + rdy_log[0] * 10 + rdy_log[1], 213);
  endtask

  task automatic test_tie();
    tie_tx_to_rx = 1'b0;
    tx_in = 4'b1010;
    drive_tx = 0;
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 4; k++) send_bit(0, 0);
    settle();
    chk(rdy_n == 0, "R10 own clock idle gives no ready", rdy_n, 0);
    chk(!s_oe[1] && !s_oe[3], "R10 line stays released", s_oe[1] + s_oe[3], 0);
    drive_tx = 1;
    clear_logs();
    send_bit(1, 0);
    for (int k = 0; k < 4; k++) send_bit(0, 0);
    settle();
    drive_tx = 0;
    chk(rdy_n == 2, "R10 own clock drives transmit", rdy_n, 2);
    chk(s_oe[1] && s_txd[1] && s_oe[3] && s_txd[3], "R10 own clock line values",
        s_oe[1] + s_txd[1] + s_oe[3] + s_txd[3], 4);
    tie_tx_to_rx = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_rx_route();
    test_rx_edge();
    test_wrap();
    test_ten_bit();
    test_strobe();
    load_tx_tbl();
    test_tx(4'b0010);
    test_tx(4'b1000);
    test_tie();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule